// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block merges eight interrupt sources into one request to a CPU and tells the CPU which source to serve. The sources are level-holding: each one keeps its line high until software clears the cause. The controller raises `cpu_irq` whenever an unmasked request may be granted under fixed priority, with input 0 highest. The CPU then answers with a two-pulse acknowledge on `ack_stb`. The first pulse fixes the winning input. During the second pulse the controller drives an 8-bit type code onto the data bus, with read-like timing. The type code is the programmable vector base plus the input number.

An in-service register remembers which inputs are being served. There are two end-of-interrupt modes. In automatic mode the second acknowledge pulse clears the in-service bit, so a request that is still held asks again at once. In specific mode the bit stays set until software writes an end-of-interrupt command naming the input. Until then that input and every input of lower priority are held off. A small write port sets the mask, the vector base and the mode, and also accepts the end-of-interrupt command.

Top module: `vic_ctrl`

## Requirements
- R1: After synchronous reset the mask, in-service bits, vector base and mode are all zero (specific end-of-interrupt mode). With no request present, `cpu_irq`, `bus_oe` and `bus_out` are all 0.
- R2: `cpu_irq` is high exactly when some unmasked input i is requesting and no in-service bit at index 0..i is set. Input 0 has the highest priority.
- R3: During the first acknowledge pulse `bus_oe` stays 0, so the bus is released.
- R4: While the strobe is high in the second acknowledge pulse, `bus_oe` is 1 and `bus_out` equals base + n (modulo 256). Here n is the input latched at the first pulse and base is written at address 1. Whenever `bus_oe` is 0, `bus_out` is 0.
- R5: When several grantable inputs are requesting at the first pulse, the lowest-numbered one is the one acknowledged.
- R6: In automatic mode (address 2, bit 0 = 1) the second pulse clears the in-service bit. A request still held then raises `cpu_irq` again right after the sequence.
- R7: In specific mode (address 2, bit 0 = 0) the acknowledged input's in-service bit stays set after the sequence. That input and all lower-priority inputs cannot raise `cpu_irq`, but higher-priority inputs can. A write to address 3 with the input number in bits 2:0 clears that bit. The in-service count grows by at most one per cycle.
- R8: The request level is taken at the first pulse. If nothing is grantable then, the code is base + 7 and no in-service bit is set.
- R9: Mask bit i (address 0, bit i = 1) stops input i from raising `cpu_irq` or being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Level request inputs, bit 0 highest priority |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| ack_stb | input | 1 | Acknowledge strobe, two pulses per acknowledge |
| bus_out | output | 8 | Type code driven on the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mask, 1 vector base, 2 mode, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The hardest state to reach from the ports is a request that vanishes after `cpu_irq` was seen but before the first pulse. The bench raises a single input, confirms `cpu_irq`, drops the line and only then starts the acknowledge. It expects base + 7 on the bus, and it then checks that input 7 can still interrupt, which proves no in-service bit was left behind. Priority blocking in specific mode is also reached only by ordering the stimulus carefully: each input in turn is acknowledged while it is still held, and then a higher and a lower neighbour are raised before the end-of-interrupt write.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int VIC_SRC_DEF = 8;
    localparam int VIC_DW_DEF  = 8;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_BASE = 2'd1,
        REG_MODE = 2'd2,
        REG_EOI  = 2'd3
    } vic_reg_e;

    typedef enum logic {
        ACK_FIRST  = 1'b0,
        ACK_SECOND = 1'b1
    } ack_phase_e;

endpackage

// File: rtl/vic_cfg.sv
module vic_cfg
    import vic_pkg::*;
#(
    parameter int N_SRC = VIC_SRC_DEF,
    parameter int DW    = VIC_DW_DEF,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [N_SRC-1:0] mask,
    output logic [DW-1:0]    base,
    output logic             auto_eoi,
    output logic             eoi_we,
    output logic [IDX_W-1:0] eoi_idx
);

    vic_reg_e sel;
    assign sel = vic_reg_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '0;
            base     <= '0;
            auto_eoi <= 1'b0;
        end else if (we) begin
            case (sel)
                REG_MASK: mask     <= wdata[N_SRC-1:0];
                REG_BASE: base     <= wdata;
                REG_MODE: auto_eoi <= wdata[0];
                default:  ;
            endcase
        end
    end

    assign eoi_we  = we && (sel == REG_EOI);
    assign eoi_idx = wdata[IDX_W-1:0];

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] isr,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx
);

    // open[i]: no in-service bit at index 0..i
    logic [N_SRC-1:0] open;
    logic [N_SRC-1:0] cand;

    assign open[0] = ~isr[0];
    for (genvar i = 1; i < N_SRC; i++) begin : g_open
        assign open[i] = open[i-1] & ~isr[i];
    end

    assign cand = req & ~mask & open;

    always_comb begin
        grant_vld = 1'b0;
        grant_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant_vld = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_ack.sv
module vic_ack
    import vic_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC),
    localparam logic [IDX_W-1:0] IDX_LOW = IDX_W'(N_SRC - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_stb,
    input  logic             grant_vld,
    input  logic [IDX_W-1:0] grant_idx,
    input  logic             auto_eoi,
    input  logic             eoi_we,
    input  logic [IDX_W-1:0] eoi_idx,
    output logic [N_SRC-1:0] isr,
    output logic [IDX_W-1:0] code_idx,
    output ack_phase_e       phase
);

    logic ack_q;
    logic rise, fall;
    logic [N_SRC-1:0] isr_nxt;

    assign rise = ack_stb & ~ack_q;
    assign fall = ~ack_stb & ack_q;

    always_comb begin
        isr_nxt = isr;
        if (rise && phase == ACK_FIRST && grant_vld)
            isr_nxt[grant_idx] = 1'b1;
        if (rise && phase == ACK_SECOND && auto_eoi)
            isr_nxt[code_idx] = 1'b0;
        if (eoi_we)
            isr_nxt[eoi_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            isr      <= '0;
            code_idx <= '0;
            phase    <= ACK_FIRST;
        end else begin
            ack_q <= ack_stb;
            isr   <= isr_nxt;
            if (rise && phase == ACK_FIRST)
                code_idx <= grant_vld ? grant_idx : IDX_LOW;
            if (fall)
                phase <= (phase == ACK_FIRST) ? ACK_SECOND : ACK_FIRST;
        end
    end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC = VIC_SRC_DEF,
    parameter int DW    = VIC_DW_DEF,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_lines,
    output logic             cpu_irq,
    input  logic             ack_stb,
    output logic [DW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [DW-1:0]    cfg_wdata
);

    logic [N_SRC-1:0] mask;
    logic [DW-1:0]    base;
    logic             auto_eoi;
    logic             eoi_we;
    logic [IDX_W-1:0] eoi_idx;
    logic [N_SRC-1:0] isr;
    logic             grant_vld;
    logic [IDX_W-1:0] grant_idx;
    logic [IDX_W-1:0] code_idx;
    ack_phase_e       ack_phase;

    vic_cfg #(.N_SRC(N_SRC), .DW(DW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mask(mask), .base(base), .auto_eoi(auto_eoi),
        .eoi_we(eoi_we), .eoi_idx(eoi_idx)
    );

    vic_prio #(.N_SRC(N_SRC)) u_prio (
        .req(irq_lines), .mask(mask), .isr(isr),
        .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    vic_ack #(.N_SRC(N_SRC)) u_ack (
        .clk(clk), .rst(rst), .ack_stb(ack_stb),
        .grant_vld(grant_vld), .grant_idx(grant_idx), .auto_eoi(auto_eoi),
        .eoi_we(eoi_we), .eoi_idx(eoi_idx),
        .isr(isr), .code_idx(code_idx), .phase(ack_phase)
    );

    assign cpu_irq = grant_vld;
    assign bus_oe  = ack_stb && (ack_phase == ACK_SECOND);
    assign bus_out = bus_oe ? base + DW'(code_idx) : '0;

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
    parameter int N_SRC = 8,
    parameter int DW    = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] irq_lines,
    input logic             cpu_irq,
    input logic             ack_stb,
    input logic             bus_oe,
    input logic [DW-1:0]    bus_out,
    input logic             cfg_we,
    input logic [N_SRC-1:0] mask,
    input logic [N_SRC-1:0] isr,
    input logic [IDX_W-1:0] code_idx,
    input logic             auto_eoi,
    input logic             ack_phase
);

    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_out == '0);

    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        ((irq_lines & ~mask) == '0) |-> !cpu_irq);

    p_top_in_service_r2: assert property (@(posedge clk) disable iff (rst)
        isr[0] |-> !cpu_irq);

    p_auto_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_eoi && ack_phase && $rose(ack_stb)) |=> !isr[code_idx]);

    p_spurious_no_isr_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_stb) && !ack_phase && !cpu_irq && !cfg_we) |=> isr == $past(isr));

    p_isr_step_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(isr) <= $countones($past(isr)) + 1);

endmodule

bind vic_ctrl vic_ctrl_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .cpu_irq(cpu_irq),
    .ack_stb(ack_stb), .bus_oe(bus_oe), .bus_out(bus_out), .cfg_we(cfg_we),
    .mask(mask), .isr(isr), .code_idx(code_idx), .auto_eoi(auto_eoi),
    .ack_phase(ack_phase)
);

// File: tb/sim_vic_ctrl.sv
module sim_vic_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_lines = '0;
    logic       cpu_irq;
    logic       ack_stb = 1'b0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vic_ctrl u0 (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .cpu_irq(cpu_irq),
        .ack_stb(ack_stb), .bus_out(bus_out), .bus_oe(bus_oe),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_lines(input logic [7:0] v);
        @(negedge clk);
        irq_lines = v;
        #1;
    endtask

    task automatic do_ack(output logic d1, output logic d2, output logic [7:0] c);
        @(negedge clk); ack_stb = 1'b1;
        @(negedge clk); d1 = bus_oe; ack_stb = 1'b0;
        @(negedge clk);
        @(negedge clk); ack_stb = 1'b1;
        @(negedge clk); d2 = bus_oe; c = bus_out; ack_stb = 1'b0;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic d1, d2;
        logic [7:0] c;
        logic [7:0] bases [2];
        bases[0] = 8'h70; bases[1] = 8'hFC;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 cpu_irq", cpu_irq, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 bus_out", bus_out, 0);
        // reset base is 0: spurious code = 7
        do_ack(d1, d2, c);
        chk("R1 base zero", c, 7);

        for (int m = 0; m < 2; m++) begin
            wr(2'd2, 8'(m));
            for (int b = 0; b < 2; b++) begin
                wr(2'd1, bases[b]);
                // single held input, both modes
                for (int i = 0; i < 8; i++) begin
                    set_lines(8'(1 << i));
                    chk("R2 raise", cpu_irq, 1);
                    do_ack(d1, d2, c);
                    chk("R3 first pulse", d1, 0);
                    chk("R4 oe", d2, 1);
                    chk("R4 code", c, 8'(bases[b] + i));
                    if (m == 1) begin
                        chk("R6 re-request", cpu_irq, 1);
                    end else begin
                        chk("R7 self blocked", cpu_irq, 0);
                        if (i > 0) begin
                            set_lines(8'((1 << i) | (1 << (i - 1))));
                            chk("R7 higher passes", cpu_irq, 1);
                        end
                        if (i < 7) begin
                            set_lines(8'((1 << i) | (1 << (i + 1))));
                            chk("R7 lower blocked", cpu_irq, 0);
                        end
                        set_lines(8'(1 << i));
                        wr(2'd3, 8'(i));
                        #1;
                        chk("R7 after eoi", cpu_irq, 1);
                    end
                    set_lines(8'h00);
                    chk("R2 drop", cpu_irq, 0);
                end
                // simultaneous pairs
                for (int i = 0; i < 8; i++) begin
                    for (int j = i + 1; j < 8; j++) begin
                        set_lines(8'((1 << i) | (1 << j)));
                        do_ack(d1, d2, c);
                        chk("R5 priority", c, 8'(bases[b] + i));
                        set_lines(8'h00);
                        wr(2'd3, 8'(i));
                    end
                end
                // request removed before first pulse
                for (int i = 0; i < 8; i++) begin
                    set_lines(8'(1 << i));
                    chk("R8 seen", cpu_irq, 1);
                    set_lines(8'h00);
                    do_ack(d1, d2, c);
                    chk("R8 default code", c, 8'(bases[b] + 7));
                    set_lines(8'h80);
                    chk("R8 nothing in service", cpu_irq, 1);
                    set_lines(8'h00);
                end
            end
        end

        // mask
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h40);
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 8'(1 << i));
            set_lines(8'(1 << i));
            chk("R9 masked", cpu_irq, 0);
            set_lines(8'hFF);
            do_ack(d1, d2, c);
            chk("R9 skip masked", c, 8'h40 + ((i == 0) ? 1 : 0));
            set_lines(8'h00);
            wr(2'd3, (i == 0) ? 8'd1 : 8'd0);
        end
        wr(2'd0, 8'h00);
        #1;
        chk("R2 idle end", cpu_irq, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule